// File: doc/BRIEF.md
# Timed-Access Register Write Guard

This block protects a small bank of critical control registers on a simple byte-wide register bus. A write to any protected register takes effect only while a short write-enable window is open. Software opens the window by writing two key bytes in a row to a dedicated unlock address: first 0xAA, then 0x55 no more than three cycles later. The window stays open for exactly four cycles and then closes without any further action. After that, the whole key sequence must be written again.

The guard watches every bus write. Key writes to the unlock address drive a small sequencer. Writes to protected addresses are turned into per-register write enables, and only while the window is open. Writes outside the window are dropped and leave no trace. The protected registers are held inside the block. They can be read back at any time on a separate read port, and their contents are also presented in parallel to the logic they control.

Top module: `ta_write_guard`

## Requirements
- R1: After a synchronous active-low reset, `win_active` is 0, `prot_we` is 0, and every protected register holds its reset value (default 0x00), as seen on `rd_data` and `prot_q`.
- R2: A write of 0xAA to the unlock address (default 0xC7), followed by a write of 0x55 to it 1, 2 or 3 cycles later, raises `win_active` in the cycle after the 0x55 write.
- R3: If 0x55 arrives 4 or more cycles after the last 0xAA, the window stays closed.
- R4: Once open, `win_active` stays high for exactly 4 consecutive cycles and then falls.
- R5: A write to a protected address while `win_active` is 0 is discarded, and the register keeps its old value.
- R6: Every protected write made while `win_active` is 1 is accepted, including several writes inside one window. `prot_we` is one-hot on the addressed register during such a write. Default addresses are 0x9F, 0xA1, 0xD8 and 0xF1 for indices 0 to 3, and `prot_q` carries index i in bits [8i+7:8i].
- R7: Reads are never gated. `rd_data` returns the addressed protected register with or without a window, and returns 0x00 for the unlock address and for any unprotected address.
- R8: After a pending 0xAA, a key write of any value other than 0x55 or 0xAA drops the sequence back to idle. A 0x55 written with no pending 0xAA opens nothing.
- R9: A second 0xAA written while a sequence is pending restarts the 3-cycle wait from that second write.
- R10: Key writes made while the window is open are ignored. They neither extend the window nor start a new sequence.
- R11: Writes to other addresses between the 0xAA and the 0x55 do not disturb the sequence.
- R12: Asserting reset closes an open window and abandons a pending sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Write address |
| bus_wdata | input | 8 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| win_active | output | 1 | Write-enable window is open |
| prot_we | output | 4 | Gated write enable, one bit per protected register |
| prot_q | output | 32 | Contents of all protected registers, packed |

## Verification
The hardest conditions to reach are the timing edges of the sequence. These are a 0x55 that lands exactly on the third cycle versus the fourth, an 0xAA re-issued mid-wait so that the deadline moves, and a key write inside an open window. Each of these depends on the exact gap in cycles between bus writes. The stimulus is therefore a cycle-by-cycle vector table that places key writes at chosen gaps and predicts `win_active` after every edge. Directed tests follow it. They fill all four window cycles with protected writes, try a write on the fifth cycle, and pulse reset both inside an open window and during a pending sequence.

// File: rtl/ta_guard_pkg.sv
// Shared types for the timed-access write guard.
// Assumes: used by every module of the guard; holds no logic.
package ta_guard_pkg;
    typedef enum logic [1:0] {
        TA_IDLE  = 2'd0,
        TA_ARMED = 2'd1,
        TA_OPEN  = 2'd2
    } ta_state_e;
endpackage

// File: rtl/ta_unlock_seq.sv
// Unlock sequencer: watches key writes and runs the arm and window timers.
// Assumes: key_wr is a single-cycle strobe already qualified by the unlock address.
module ta_unlock_seq
    import ta_guard_pkg::*;
#(
    parameter int          DW         = 8,
    parameter logic [DW-1:0] KEY_FIRST  = 8'hAA,
    parameter logic [DW-1:0] KEY_SECOND = 8'h55,
    parameter int          ARM_CYCLES = 3,
    parameter int          WIN_CYCLES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          key_wr,
    input  logic [DW-1:0] key_data,
    output logic          win_active
);
    localparam int MAXC  = (ARM_CYCLES > WIN_CYCLES) ? ARM_CYCLES : WIN_CYCLES;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] ARM_LOAD = CNT_W'(ARM_CYCLES);
    localparam logic [CNT_W-1:0] WIN_LOAD = CNT_W'(WIN_CYCLES);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    ta_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // Next-state and timer reload/decrement for the sequencer.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        case (state_q)
            TA_IDLE: begin
                if (key_wr && key_data == KEY_FIRST) begin
                    state_d = TA_ARMED;
                    cnt_d   = ARM_LOAD;
                end
            end
            TA_ARMED: begin
                if (key_wr) begin
                    if (key_data == KEY_SECOND) begin
                        state_d = TA_OPEN;
                        cnt_d   = WIN_LOAD;
                    end else if (key_data == KEY_FIRST) begin
                        cnt_d   = ARM_LOAD;
                    end else begin
                        state_d = TA_IDLE;
                        cnt_d   = '0;
                    end
                end else if (cnt_q <= ONE) begin
                    state_d = TA_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d   = cnt_q - ONE;
                end
            end
            TA_OPEN: begin
                if (cnt_q <= ONE) begin
                    state_d = TA_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d   = cnt_q - ONE;
                end
            end
            default: begin
                state_d = TA_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State and timer registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TA_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign win_active = (state_q == TA_OPEN);
endmodule

// File: rtl/ta_addr_match.sv
// Address decoder: compares one address against the protected address list.
// Assumes: list entries are distinct, so the result is one-hot or zero.
module ta_addr_match #(
    parameter int                 AW     = 8,
    parameter int                 N_PROT = 4,
    parameter logic [N_PROT*AW-1:0] ADDRS  = '0
) (
    input  logic [AW-1:0]     addr,
    output logic [N_PROT-1:0] hit
);
    genvar i;
    generate
        for (i = 0; i < N_PROT; i++) begin : g_cmp
            // One comparator per protected address.
            assign hit[i] = (addr == ADDRS[i*AW +: AW]);
        end
    endgenerate
endmodule

// File: rtl/ta_prot_regs.sv
// Protected register bank: per-entry write enable and an ungated read mux.
// Assumes: we is already gated by the window; rd_hit is one-hot or zero.
module ta_prot_regs #(
    parameter int                 DW     = 8,
    parameter int                 N_PROT = 4,
    parameter logic [N_PROT*DW-1:0] INIT   = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_PROT-1:0]    we,
    input  logic [DW-1:0]        wdata,
    input  logic [N_PROT-1:0]    rd_hit,
    output logic [DW-1:0]        rd_data,
    output logic [N_PROT*DW-1:0] q_flat
);
    logic [DW-1:0] q [N_PROT];

    genvar i;
    generate
        for (i = 0; i < N_PROT; i++) begin : g_reg
            // Storage for one protected register.
            always_ff @(posedge clk) begin
                if (!rst_n)     q[i] <= INIT[i*DW +: DW];
                else if (we[i]) q[i] <= wdata;
            end
            assign q_flat[i*DW +: DW] = q[i];
        end
    endgenerate

    // Read mux; reads zero when no protected entry is addressed.
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < N_PROT; k++) begin
            if (rd_hit[k]) rd_data = rd_data | q[k];
        end
    end
endmodule

// File: rtl/ta_write_guard.sv
// Top of the timed-access write guard: decodes the bus, runs the unlock
// sequencer and gates writes to the protected register bank.
// Assumes: one bus write per cycle; unlock address is not in the protected list.
module ta_write_guard #(
    parameter int                  DW         = 8,
    parameter int                  AW         = 8,
    parameter int                  N_PROT     = 4,
    parameter logic [AW-1:0]        KEY_ADDR   = 8'hC7,
    parameter logic [DW-1:0]        KEY_FIRST  = 8'hAA,
    parameter logic [DW-1:0]        KEY_SECOND = 8'h55,
    parameter int                  ARM_CYCLES = 3,
    parameter int                  WIN_CYCLES = 4,
    parameter logic [N_PROT*AW-1:0] PROT_ADDRS = {8'hF1, 8'hD8, 8'hA1, 8'h9F},
    parameter logic [N_PROT*DW-1:0] PROT_INIT  = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [AW-1:0]        bus_addr,
    input  logic [DW-1:0]        bus_wdata,
    input  logic [AW-1:0]        rd_addr,
    output logic [DW-1:0]        rd_data,
    output logic                 win_active,
    output logic [N_PROT-1:0]    prot_we,
    output logic [N_PROT*DW-1:0] prot_q
);
    logic              key_wr;
    logic [N_PROT-1:0] wr_hit;
    logic [N_PROT-1:0] rd_hit;

    // Key writes are bus writes to the unlock address.
    assign key_wr = bus_wr && (bus_addr == KEY_ADDR);

    ta_unlock_seq #(
        .DW(DW), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND),
        .ARM_CYCLES(ARM_CYCLES), .WIN_CYCLES(WIN_CYCLES)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .key_wr(key_wr),
        .key_data(bus_wdata), .win_active(win_active)
    );

    ta_addr_match #(.AW(AW), .N_PROT(N_PROT), .ADDRS(PROT_ADDRS)) u_wr_dec (
        .addr(bus_addr), .hit(wr_hit)
    );

    ta_addr_match #(.AW(AW), .N_PROT(N_PROT), .ADDRS(PROT_ADDRS)) u_rd_dec (
        .addr(rd_addr), .hit(rd_hit)
    );

    // Write enables pass only while the window is open.
    assign prot_we = wr_hit & {N_PROT{bus_wr && win_active}};

    ta_prot_regs #(.DW(DW), .N_PROT(N_PROT), .INIT(PROT_INIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(prot_we), .wdata(bus_wdata),
        .rd_hit(rd_hit), .rd_data(rd_data), .q_flat(prot_q)
    );
endmodule

// File: rtl/ta_write_guard_chk.sv
// Property checker for the write guard, attached to the top by bind.
// Assumes: observes top-level ports only.
module ta_write_guard_chk #(
    parameter int            DW         = 8,
    parameter int            AW         = 8,
    parameter int            N_PROT     = 4,
    parameter logic [AW-1:0] KEY_ADDR   = 8'hC7,
    parameter logic [DW-1:0] KEY_SECOND = 8'h55,
    parameter int            WIN_CYCLES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr,
    input logic [AW-1:0]        bus_addr,
    input logic [DW-1:0]        bus_wdata,
    input logic                 win_active,
    input logic [N_PROT-1:0]    prot_we,
    input logic [N_PROT*DW-1:0] prot_q
);
    localparam int RW = $clog2(WIN_CYCLES + 2);
    logic [RW-1:0] run_q;

    // Counts consecutive open-window cycles already seen.
    always_ff @(posedge clk) begin
        if (!rst_n)          run_q <= '0;
        else if (win_active) run_q <= run_q + RW'(1);
        else                 run_q <= '0;
    end

    p_window_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
        win_active |-> (run_q < RW'(WIN_CYCLES)));

    p_window_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(win_active) && $past(rst_n)) |-> (run_q == RW'(WIN_CYCLES)));

    p_open_after_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_active) |-> $past(bus_wr && bus_addr == KEY_ADDR && bus_wdata == KEY_SECOND));

    p_closed_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !win_active |=> $stable(prot_q));

    p_we_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|prot_we) |-> (win_active && bus_wr));

    p_we_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(prot_we));

    p_reset_closes_r12: assert property (@(posedge clk)
        !rst_n |=> !win_active);
endmodule

bind ta_write_guard ta_write_guard_chk #(
    .DW(DW), .AW(AW), .N_PROT(N_PROT), .KEY_ADDR(KEY_ADDR),
    .KEY_SECOND(KEY_SECOND), .WIN_CYCLES(WIN_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .win_active(win_active), .prot_we(prot_we),
    .prot_q(prot_q)
);

// File: tb/ta_write_guard_tb.sv
`timescale 1ns/1ps
module ta_write_guard_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        win_active;
    logic [3:0]  prot_we;
    logic [31:0] prot_q;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ta_write_guard u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
        .win_active(win_active), .prot_we(prot_we), .prot_q(prot_q)
    );

    // Vector: {tag[3:0], wr, addr[7:0], data[7:0], expected win_active after edge}
    localparam int NV = 40;
    localparam logic [21:0] VEC [NV] = '{
        {4'd2,  1'b1, 8'hC7, 8'hAA, 1'b0},  // 0  arm
        {4'd2,  1'b1, 8'hC7, 8'h55, 1'b1},  // 1  gap 1 opens
        {4'd4,  1'b0, 8'h00, 8'h00, 1'b1},
        {4'd4,  1'b0, 8'h00, 8'h00, 1'b1},
        {4'd4,  1'b0, 8'h00, 8'h00, 1'b1},
        {4'd4,  1'b0, 8'h00, 8'h00, 1'b0},  // 5  closes after 4
        {4'd2,  1'b1, 8'hC7, 8'hAA, 1'b0},
        {4'd2,  1'b0, 8'h00, 8'h00, 1'b0},
        {4'd2,  1'b0, 8'h00, 8'h00, 1'b0},
        {4'd2,  1'b1, 8'hC7, 8'h55, 1'b1},  // 9  gap 3 opens
        {4'd10, 1'b1, 8'hC7, 8'hAA, 1'b1},  // 10 key write in window
        {4'd10, 1'b0, 8'h00, 8'h00, 1'b1},
        {4'd10, 1'b0, 8'h00, 8'h00, 1'b1},
        {4'd10, 1'b0, 8'h00, 8'h00, 1'b0},  // 13 no extension
        {4'd8,  1'b1, 8'hC7, 8'h55, 1'b0},  // 14 0x55 from idle
        {4'd3,  1'b1, 8'hC7, 8'hAA, 1'b0},
        {4'd3,  1'b0, 8'h00, 8'h00, 1'b0},
        {4'd3,  1'b0, 8'h00, 8'h00, 1'b0},
        {4'd3,  1'b0, 8'h00, 8'h00, 1'b0},
        {4'd3,  1'b1, 8'hC7, 8'h55, 1'b0},  // 19 gap 4 too late
        {4'd8,  1'b1, 8'hC7, 8'hAA, 1'b0},
        {4'd8,  1'b1, 8'hC7, 8'h33, 1'b0},  // 21 wrong byte
        {4'd8,  1'b1, 8'hC7, 8'h55, 1'b0},
        {4'd9,  1'b1, 8'hC7, 8'hAA, 1'b0},
        {4'd9,  1'b0, 8'h00, 8'h00, 1'b0},
        {4'd9,  1'b1, 8'hC7, 8'hAA, 1'b0},  // 25 restart
        {4'd9,  1'b0, 8'h00, 8'h00, 1'b0},
        {4'd9,  1'b0, 8'h00, 8'h00, 1'b0},
        {4'd9,  1'b1, 8'hC7, 8'h55, 1'b1},  // 28 gap 3 from second 0xAA
        {4'd4,  1'b0, 8'h00, 8'h00, 1'b1},
        {4'd4,  1'b0, 8'h00, 8'h00, 1'b1},
        {4'd4,  1'b0, 8'h00, 8'h00, 1'b1},
        {4'd4,  1'b0, 8'h00, 8'h00, 1'b0},
        {4'd11, 1'b1, 8'hC7, 8'hAA, 1'b0},
        {4'd11, 1'b1, 8'h9F, 8'h11, 1'b0},  // 34 other write between keys
        {4'd11, 1'b1, 8'hC7, 8'h55, 1'b1},
        {4'd4,  1'b0, 8'h00, 8'h00, 1'b1},
        {4'd4,  1'b0, 8'h00, 8'h00, 1'b1},
        {4'd4,  1'b0, 8'h00, 8'h00, 1'b1},
        {4'd4,  1'b0, 8'h00, 8'h00, 1'b0}
    };

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd2:  return "R2";
            4'd3:  return "R3";
            4'd4:  return "R4";
            4'd8:  return "R8";
            4'd9:  return "R9";
            4'd10: return "R10";
            4'd11: return "R11";
            default: return "R?";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one cycle of bus activity; returns just after the sampling edge.
    task automatic step(input logic wr, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
    endtask

    task automatic read_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        rd_addr = a;
        #1;
        check(req, {24'h0, rd_data}, {24'h0, exp});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_wr = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #400000;
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        do_reset();
        do_reset();
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 win", {31'h0, win_active}, 32'h0);
        check("R1 we", {28'h0, prot_we}, 32'h0);
        check("R1 q", prot_q, 32'h0);
        read_chk("R1 rd", 8'hD8, 8'h00);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][17], VEC[i][16:9], VEC[i][8:1]);
            check(tag_name(VEC[i][21:18]), {31'h0, win_active}, {31'h0, VEC[i][0]});
        end
        step(1'b0, 8'h00, 8'h00);

        // R11 write at vector 34 was outside a window: discarded
        read_chk("R5 vec34", 8'h9F, 8'h00);
        // R5 closed write
        step(1'b1, 8'h9F, 8'h5A);
        step(1'b0, 8'h00, 8'h00);
        read_chk("R5 closed", 8'h9F, 8'h00);

        // R6 four writes filling one window
        step(1'b1, 8'hC7, 8'hAA);
        step(1'b1, 8'hC7, 8'h55);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h9F; bus_wdata = 8'h12;
        #1;
        check("R6 we0", {28'h0, prot_we}, 32'h1);
        @(posedge clk);
        #1;
        step(1'b1, 8'hA1, 8'h34);
        step(1'b1, 8'hD8, 8'h56);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'hF1; bus_wdata = 8'h78;
        #1;
        check("R6 we3", {28'h0, prot_we}, 32'h8);
        @(posedge clk);
        #1;
        // fifth cycle: window closed, write dropped
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h9F; bus_wdata = 8'hFF;
        #1;
        check("R4 fifth", {27'h0, win_active, prot_we}, 32'h0);
        @(posedge clk);
        #1;
        step(1'b0, 8'h00, 8'h00);
        read_chk("R6 rd0", 8'h9F, 8'h12);
        read_chk("R6 rd1", 8'hA1, 8'h34);
        read_chk("R6 rd2", 8'hD8, 8'h56);
        read_chk("R6 rd3", 8'hF1, 8'h78);
        check("R6 q", prot_q, 32'h78563412);

        // R7 reads of unlock and unrelated addresses
        read_chk("R7 key", 8'hC7, 8'h00);
        read_chk("R7 other", 8'h10, 8'h00);

        // R12 reset inside an open window
        step(1'b1, 8'hC7, 8'hAA);
        step(1'b1, 8'hC7, 8'h55);
        check("R12 open", {31'h0, win_active}, 32'h1);
        do_reset();
        check("R12 closed", {31'h0, win_active}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        read_chk("R1 after", 8'hA1, 8'h00);
        step(1'b1, 8'h9F, 8'hAB);
        step(1'b0, 8'h00, 8'h00);
        read_chk("R12 drop", 8'h9F, 8'h00);

        // R12 reset while pending
        step(1'b1, 8'hC7, 8'hAA);
        do_reset();
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b1, 8'hC7, 8'h55);
        check("R12 pending", {31'h0, win_active}, 32'h0);
        step(1'b0, 8'h00, 8'h00);

        finish_run();
    end
endmodule